// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is being held low by a target that lost track of a transfer. It watches the two bus lines through synchronizers, reports their live levels and keeps a bus-busy flag that follows START and STOP conditions seen on the wire. When software issues a recovery command, the block clocks SCL while SDA stays low. It stops as soon as SDA is seen high at the end of an SCL-high phase. It never issues more than a fixed burst of pulses.

When SDA comes free, the block closes the bus with a STOP condition, sets a "freed" flag and clears bus busy. If SDA is still low after the last pulse, it sets a timeout flag instead. Either way it ends with a one-cycle done pulse. A base tick input paces the SCL half-periods, so the bus rate is set outside the block. The drive outputs are open-drain style: a 1 pulls the line low.

Top module: `i2c_bus_unstick`

## Requirements
- R1: `line_scl` and `line_sda` follow the SCL and SDA inputs after the synchronizer delay (SYNC_STAGES cycles); both read 1 after reset.
- R2: While no recovery is running, SDA falling while SCL is high (a START) sets `bus_busy`; `bus_busy` is 0 after reset.
- R3: While no recovery is running, SDA rising while SCL is high (a STOP) clears `bus_busy`.
- R4: A one-cycle `recover_go` while idle starts a sequence that produces at least one SCL pulse, even if SDA is already high.
- R5: SDA is sampled at the end of each SCL-high phase (each phase is HALF_TICKS ticks). If SDA is high there, pulsing stops, so a target that releases during pulse K sees exactly K pulses.
- R6: No more than MAX_PULSES (default 8) SCL pulses are issued. If SDA is still low after the last one, `sda_stuck_timeout` is set to 1, `sda_freed` stays 0 and `recover_done` still pulses.
- R7: After SDA is released, the block drives a STOP. It first pulls SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high. It then sets `sda_freed` to 1.
- R8: `recover_done` is high for exactly one cycle at the end of each sequence.
- R9: A `recover_go` that arrives while a sequence is running has no effect: exactly one `recover_done` occurs and the pulse count is unchanged.
- R10: A sequence ending with `sda_freed`=1 clears `bus_busy`. A sequence ending in timeout leaves `bus_busy` as it was.
- R11: `sda_freed` and `sda_stuck_timeout` hold their value after a sequence. Both are cleared when the next sequence starts.
- R12: While idle, `scl_drive_low` and `sda_drive_low` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| recover_go | input | 1 | One-cycle recovery command strobe |
| tick | input | 1 | Base tick pacing SCL half-periods |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| line_scl | output | 1 | Synchronized SCL level |
| line_sda | output | 1 | Synchronized SDA level |
| bus_busy | output | 1 | Bus held between START and STOP |
| sda_freed | output | 1 | Last sequence released SDA |
| recover_done | output | 1 | One-cycle end-of-sequence pulse |
| sda_stuck_timeout | output | 1 | Last sequence exhausted its pulses with SDA low |

## Verification
The hardest case to reach from the ports is a target that lets go of SDA at one exact pulse. A plain stuck-low input cannot produce it. The bench therefore models a target on the wired-AND bus that counts the SCL rising edges the block produces and releases SDA on a chosen edge. This sweeps the release point from "already free" through the last allowed pulse to "never". To reach the no-START hold case, where SDA is held low without setting busy, the bench first forces SCL low, then lets the target grab SDA, then releases SCL.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLK_LO = 3'd1,
    ST_CLK_HI = 3'd2,
    ST_STP_LO = 3'd3,
    ST_STP_HI = 3'd4
  } seq_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/unstick_bus_monitor.sv
module unstick_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic mask,
  input  logic clr,
  output logic busy
);
  logic scl_p_q, sda_p_q, busy_q, busy_d;
  logic start_seen, stop_seen;

  assign start_seen = !mask && scl_s && scl_p_q && sda_p_q && !sda_s;
  assign stop_seen  = !mask && scl_s && scl_p_q && !sda_p_q && sda_s;

  always_comb begin
    busy_d = busy_q;
    if (start_seen)             busy_d = 1'b1;
    else if (stop_seen || clr)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
      busy_q  <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/unstick_seq.sv
module unstick_seq
  import i2c_unstick_pkg::*;
#(
  parameter int MAX_PULSES = 8,
  parameter int HALF_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tick,
  input  logic sda_s,
  output logic scl_dl,
  output logic sda_dl,
  output logic active,
  output logic done,
  output logic freed,
  output logic timeout,
  output logic clr_busy
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam int HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [HW-1:0] HALF_LAST  = HW'(HALF_TICKS - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(MAX_PULSES - 1);

  seq_state_e      state_q, state_d;
  logic [HW-1:0]   ph_q, ph_d;
  logic [PW-1:0]   np_q, np_d;
  logic            done_q, done_d;
  logic            freed_q, freed_d;
  logic            to_q, to_d;
  logic            half_end;

  assign half_end = tick && (ph_q == HALF_LAST);

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    np_d    = np_q;
    freed_d = freed_q;
    to_d    = to_q;
    done_d  = 1'b0;
    if (state_q != ST_IDLE && tick) begin
      ph_d = half_end ? '0 : ph_q + HW'(1);
    end
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_CLK_LO;
          ph_d    = '0;
          np_d    = '0;
          freed_d = 1'b0;
          to_d    = 1'b0;
        end
      end
      ST_CLK_LO: if (half_end) state_d = ST_CLK_HI;
      ST_CLK_HI: begin
        if (half_end) begin
          np_d = np_q + PW'(1);
          if (sda_s) begin
            state_d = ST_STP_LO;
          end else if (np_q == PULSE_LAST) begin
            state_d = ST_IDLE;
            to_d    = 1'b1;
            done_d  = 1'b1;
          end else begin
            state_d = ST_CLK_LO;
          end
        end
      end
      ST_STP_LO: if (half_end) state_d = ST_STP_HI;
      ST_STP_HI: begin
        if (half_end) begin
          state_d = ST_IDLE;
          freed_d = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      np_q    <= '0;
      done_q  <= 1'b0;
      freed_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      np_q    <= np_d;
      done_q  <= done_d;
      freed_q <= freed_d;
      to_q    <= to_d;
    end
  end

  assign scl_dl   = (state_q == ST_CLK_LO) || (state_q == ST_STP_LO);
  assign sda_dl   = (state_q == ST_STP_LO) || (state_q == ST_STP_HI);
  assign active   = (state_q != ST_IDLE);
  assign done     = done_q;
  assign freed    = freed_q;
  assign timeout  = to_q;
  assign clr_busy = done_q && freed_q;
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int MAX_PULSES  = 8,
  parameter int HALF_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_go,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic line_scl,
  output logic line_sda,
  output logic bus_busy,
  output logic sda_freed,
  output logic recover_done,
  output logic sda_stuck_timeout
);
  logic rst_sync_n;
  logic scl_s, sda_s;
  logic seq_active, clr_busy;

  unstick_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  unstick_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(scl_in), .q(scl_s));

  unstick_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(sda_in), .q(sda_s));

  unstick_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_s(sda_s),
    .mask(seq_active), .clr(clr_busy), .busy(bus_busy));

  unstick_seq #(.MAX_PULSES(MAX_PULSES), .HALF_TICKS(HALF_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go(recover_go), .tick(tick),
    .sda_s(sda_s), .scl_dl(scl_drive_low), .sda_dl(sda_drive_low),
    .active(seq_active), .done(recover_done), .freed(sda_freed),
    .timeout(sda_stuck_timeout), .clr_busy(clr_busy));

  assign line_scl = scl_s;
  assign line_sda = sda_s;
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
  parameter int MAX_PULSES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic active,
  input logic scl_dl,
  input logic sda_dl,
  input logic done,
  input logic freed,
  input logic timeout,
  input logic busy
);
  localparam int CW = $clog2(MAX_PULSES + 2);
  logic [CW-1:0] cnt_q;
  logic          scl_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      scl_p_q <= 1'b0;
    end else begin
      scl_p_q <= scl_dl;
      if (go && !active)                   cnt_q <= '0;
      else if (scl_p_q && !scl_dl && !sda_dl && cnt_q != '1) cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PULSES));
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(freed && timeout));
  assert_timeout_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
  assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && freed) |=> !busy);
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_dl) |-> !scl_dl);
  assert_stop_grab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_dl) |-> scl_dl);
  assert_start_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(go));
  assert_quiet_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_dl && !sda_dl));
endmodule

bind i2c_bus_unstick unstick_checker #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .go(recover_go), .active(seq_active),
  .scl_dl(scl_drive_low), .sda_dl(sda_drive_low), .done(recover_done),
  .freed(sda_freed), .timeout(sda_stuck_timeout), .busy(bus_busy));

// File: tb/tb_i2c_bus_unstick.sv
module tb_i2c_bus_unstick;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic tick = 1'b0;
  logic hold = 1'b0;
  logic force_scl = 1'b0;
  logic scl_dl, sda_dl, l_scl, l_sda, busy, freed, done, tout;
  logic scl_bus, sda_bus;

  int n_checks = 0;
  int n_fail = 0;
  int hold_k = 0;
  int seen = 0;
  int pulse_cnt = 0;
  int done_cnt = 0;
  bit stop_ok = 1'b1;
  logic prev_scl_dl = 1'b0;
  logic prev_sda_dl = 1'b0;
  int tdiv = 0;

  always #10 clk = ~clk;

  assign scl_bus = !scl_dl && !force_scl;
  assign sda_bus = !sda_dl && !hold;

  i2c_bus_unstick dut (
    .clk(clk), .rst_n(rst_n), .recover_go(go), .tick(tick),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_drive_low(scl_dl),
    .sda_drive_low(sda_dl), .line_scl(l_scl), .line_sda(l_sda),
    .bus_busy(busy), .sda_freed(freed), .recover_done(done),
    .sda_stuck_timeout(tout));

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 3);
    if (prev_scl_dl && !scl_dl && !sda_dl) begin
      pulse_cnt++;
      if (hold && hold_k != 9) begin
        seen++;
        if (seen == hold_k) hold = 1'b0;
      end
    end
    if (prev_sda_dl && !sda_dl && scl_dl) stop_ok = 1'b0;
    if (!prev_sda_dl && sda_dl && !scl_dl) stop_ok = 1'b0;
    if (done) done_cnt++;
    prev_scl_dl = scl_dl;
    prev_sda_dl = sda_dl;
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_go();
    go = 1'b1; step(1); go = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 3000) begin step(1); n++; end
  endtask

  // vector: [11] extra command mid-run, [10] START before, [9] exp freed,
  //         [8] exp timeout, [7:4] exp pulses, [3:0] release edge (9 = never)
  localparam logic [11:0] VECS [8] = '{
    12'h210, 12'h211, 12'h633, 12'h288, 12'h589, 12'hA55, 12'hE22, 12'h189 };

  task automatic run_vec(input logic [11:0] v);
    bit mk_start = v[10];
    hold_k = int'(v[3:0]);
    seen = 0;
    if (hold_k != 0) begin
      if (mk_start) hold = 1'b1;
      else begin
        force_scl = 1'b1; step(2); hold = 1'b1; step(2); force_scl = 1'b0;
      end
    end
    step(6);
    chk(busy == mk_start, "R2 busy before recovery", busy, mk_start);
    pulse_cnt = 0; done_cnt = 0; stop_ok = 1'b1;
    pulse_go();
    if (v[11]) begin step(10); pulse_go(); end
    wait_done();
    chk(done_cnt == 1, "R8 done seen", done_cnt, 1);
    chk(pulse_cnt == int'(v[7:4]), "R5 R6 pulse count", pulse_cnt, int'(v[7:4]));
    chk(tout == v[8], "R6 timeout flag", tout, v[8]);
    chk(freed == v[9], "R7 freed flag", freed, v[9]);
    if (v[9]) chk(stop_ok, "R7 stop ordering", stop_ok, 1);
    step(8);
    chk(done_cnt == 1, v[11] ? "R9 single done with extra command" : "R8 single done",
        done_cnt, 1);
    chk(busy == (mk_start && !v[9]), "R10 busy after recovery", busy, mk_start && !v[9]);
    chk(!scl_dl && !sda_dl, "R12 idle drives", {scl_dl, sda_dl}, 0);
    hold = 1'b0;
    step(8);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    chk(busy == 0, "R2 reset busy", busy, 0);
    chk(l_scl == 1 && l_sda == 1, "R1 reset lines", {l_scl, l_sda}, 3);
    chk(!scl_dl && !sda_dl, "R12 reset drives", {scl_dl, sda_dl}, 0);
    chk(!done && !freed && !tout, "R11 reset flags", {done, freed, tout}, 0);

    force_scl = 1'b1; step(3);
    chk(l_scl == 0, "R1 scl low mirrored", l_scl, 0);
    chk(busy == 0, "R2 scl alone no start", busy, 0);
    force_scl = 1'b0; step(3);
    chk(l_scl == 1, "R1 scl high mirrored", l_scl, 1);

    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    chk(tout == 1, "R11 timeout held after run", tout, 1);
    hold_k = 0; done_cnt = 0; pulse_cnt = 0;
    pulse_go(); step(1);
    chk(tout == 0 && freed == 0, "R11 flags cleared at start", {freed, tout}, 0);
    wait_done();
    chk(freed == 1 && pulse_cnt == 1, "R4 single pulse with free bus", pulse_cnt, 1);
    step(4);

    hold = 1'b1; step(6);
    chk(busy == 1, "R2 start sets busy", busy, 1);
    chk(l_sda == 0, "R1 sda low mirrored", l_sda, 0);
    hold = 1'b0; step(6);
    chk(busy == 0, "R3 stop clears busy", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule